// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers every exception request of a small microcontroller core and, when the CPU asks for a vector, supplies the 16-bit address of the service routine it should run. The request classes are a bank of ordinary sources gated by the CPU's I mask bit, one source gated by the X mask bit, a combined software-interrupt or debug request, an unimplemented-opcode trap, and three reset causes. All vectors except the reset ones sit in one 256-byte page. The page's high byte comes from a programmable base register, and each source has a fixed low byte within that page.

The CPU pulses a fetch strobe. At the clock edge that samples the strobe, the block picks the highest-priority enabled request and latches its vector. The vector then stays on the output until the next fetch. If nothing enabled is pending at that moment, the block supplies a spurious vector instead. A combinational wake-up output rises as soon as any enabled request is pending, so it can restart a core whose clock is stopped. While the core is frozen for debug, the page byte is forced to all ones and the programmed value is ignored.

Top module: `irq_vector_sel`

## Requirements
- R1: After reset the latched vector output is 0xFFFE, the base register holds 0xFF and wake is low while no request is driven.
- R2: The vector output changes only at a clock edge where `vec_fetch` is high. It shows the new vector from the cycle after that edge and keeps it until the next fetch.
- R3: Any set bit of `rst_cause` wins over every other request. Bit 2 gives 0xFFFE, bit 1 gives 0xFFFC and bit 0 gives 0xFFFA. A higher bit wins over a lower bit. The base register and freeze have no effect on these vectors.
- R4: `trap_req` yields {page, 0xF8}. It wins over `swi_req` and all lower classes, and no mask bit affects it.
- R5: `swi_req` yields {page, 0xF6}. It wins over the X and I sources, and no mask bit affects it.
- R6: When `x_mask` is 0, `xirq_req` yields {page, 0xF4} and wins over all I sources. When `x_mask` is 1 the request is ignored.
- R7: When `i_mask` is 0, I source k (bit k of `irq_req`) yields {page, 0x82 + 2k}. Among several pending I sources, the highest index wins.
- R8: When `i_mask` is 1, every I source is ignored for both vector selection and wake-up.
- R9: A fetch with no enabled request pending yields the spurious vector {page, 0x80}.
- R10: A clock edge with `base_wr` high loads `base_wdata` into the base register. Outside freeze, the register supplies the page byte.
- R11: While `freeze` is 1 the page byte is 0xFF. When freeze ends, the programmed value applies again.
- R12: `wake` is high, with no clock edge needed, whenever a reset cause, trap, software interrupt, unmasked X request or unmasked I request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_IRQ | I-maskable request lines, index k gets offset 0x82+2k |
| xirq_req | input | 1 | X-maskable request |
| swi_req | input | 1 | Software interrupt or debug request |
| trap_req | input | 1 | Unimplemented-opcode trap |
| rst_cause | input | 3 | Reset cause lines (bit 2 highest) |
| i_mask | input | 1 | CPU I mask bit, 1 blocks I sources |
| x_mask | input | 1 | CPU X mask bit, 1 blocks the X source |
| vec_fetch | input | 1 | CPU vector-fetch strobe |
| base_wr | input | 1 | Write enable for the base register |
| base_wdata | input | 8 | New base register value |
| freeze | input | 1 | Debug freeze, forces page byte 0xFF |
| vec_addr | output | 16 | Latched vector address |
| wake | output | 1 | Wake-up request for stop or wait mode |

## Verification
Fetches are issued with single I sources at both ends of the bank and with two I sources together. This separates a correct offset formula from a correct priority order. Requests are then stacked one class at a time (I under X, X under software interrupt, software interrupt under trap, trap under each reset cause), with masks toggled. Each step shows that the class boundary and the mask gating are right. Fetches with nothing pending and with freeze toggled tell the page byte source apart from the offset. Input changes between fetches, and wake probes taken before any clock edge, show the latching and the clockless wake path.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam logic [7:0] OFF_SPUR   = 8'h80;
  localparam logic [7:0] OFF_IRQ_LO = 8'h82;
  localparam logic [7:0] OFF_XIRQ   = 8'hF4;
  localparam logic [7:0] OFF_SWI    = 8'hF6;
  localparam logic [7:0] OFF_TRAP   = 8'hF8;
  localparam logic [7:0] BASE_RST   = 8'hFF;
  localparam logic [7:0] BASE_FRZ   = 8'hFF;
  localparam logic [15:0] RST_VEC_LO = 16'hFFFA;
  localparam logic [15:0] VEC_POR    = 16'hFFFE;
  localparam int NUM_RST = 3;

  typedef enum logic [2:0] {
    SRC_SPUR, SRC_IRQ, SRC_XIRQ, SRC_SWI, SRC_TRAP, SRC_RST
  } src_e;
endpackage

// File: rtl/irqv_base_reg.sv
module irqv_base_reg
  import irqv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         freeze,
  output logic [W-1:0] base_eff
);
  logic [W-1:0] base_q, base_d;

  always_comb begin
    base_d = base_q;
    if (wr_en) base_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= W'(BASE_RST);
    else        base_q <= base_d;
  end

  // Debug freeze substitutes a fixed page byte for the programmed one.
  always_comb base_eff = freeze ? W'(BASE_FRZ) : base_q;
endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
  parameter int N  = 57,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N:0]   hi;   // hi[i]: some request at index >= i
  logic [N-1:0] sel;  // one-hot winner

  assign hi[N] = 1'b0;

  genvar g;
  generate
    for (g = N - 1; g >= 0; g--) begin : g_chain
      assign hi[g]  = hi[g+1] | req[g];
      assign sel[g] = req[g] & ~hi[g+1];
    end
  endgenerate

  assign any = hi[0];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      idx = idx | (IW'(i) & {IW{sel[i]}});
    end
  end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int IW = 6
) (
  input  logic [NUM_RST-1:0] rst_cause,
  input  logic               trap_req,
  input  logic               swi_req,
  input  logic               xirq_req,
  input  logic               x_mask,
  input  logic               irq_any,
  input  logic [IW-1:0]      irq_idx,
  input  logic [7:0]         base,
  output logic [15:0]        vec_next,
  output src_e               src,
  output logic               wake
);
  logic       x_live;
  logic [7:0] irq_off;
  logic [15:0] rst_vec;

  assign x_live  = xirq_req & ~x_mask;
  assign irq_off = OFF_IRQ_LO + 8'({irq_idx, 1'b0});

  always_comb begin
    rst_vec = VEC_POR;
    for (int k = 0; k < NUM_RST; k++) begin
      if (rst_cause[k]) rst_vec = RST_VEC_LO + 16'(2 * k);
    end
  end

  always_comb begin
    if (|rst_cause)    src = SRC_RST;
    else if (trap_req) src = SRC_TRAP;
    else if (swi_req)  src = SRC_SWI;
    else if (x_live)   src = SRC_XIRQ;
    else if (irq_any)  src = SRC_IRQ;
    else               src = SRC_SPUR;
  end

  always_comb begin
    unique case (src)
      SRC_RST:  vec_next = rst_vec;
      SRC_TRAP: vec_next = {base, OFF_TRAP};
      SRC_SWI:  vec_next = {base, OFF_SWI};
      SRC_XIRQ: vec_next = {base, OFF_XIRQ};
      SRC_IRQ:  vec_next = {base, irq_off};
      default:  vec_next = {base, OFF_SPUR};
    endcase
  end

  assign wake = (src != SRC_SPUR);
endmodule

// File: rtl/irq_vector_sel.sv
module irq_vector_sel
  import irqv_pkg::*;
#(
  parameter int NUM_IRQ = 57
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               xirq_req,
  input  logic               swi_req,
  input  logic               trap_req,
  input  logic [2:0]         rst_cause,
  input  logic               i_mask,
  input  logic               x_mask,
  input  logic               vec_fetch,
  input  logic               base_wr,
  input  logic [7:0]         base_wdata,
  input  logic               freeze,
  output logic [15:0]        vec_addr,
  output logic               wake
);
  localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] irq_live;
  logic               irq_any;
  logic [IW-1:0]      irq_idx;
  logic [7:0]         base_eff;
  logic [15:0]        vec_next, vec_d, vec_q;
  src_e               src;

  assign irq_live = irq_req & {NUM_IRQ{~i_mask}};

  irqv_base_reg #(.W(8)) u_base (
    .clk(clk), .rst_n(rst_n), .wr_en(base_wr), .wr_data(base_wdata),
    .freeze(freeze), .base_eff(base_eff)
  );

  irqv_prio_enc #(.N(NUM_IRQ), .IW(IW)) u_enc (
    .req(irq_live), .any(irq_any), .idx(irq_idx)
  );

  irqv_arbiter #(.IW(IW)) u_arb (
    .rst_cause(rst_cause), .trap_req(trap_req), .swi_req(swi_req),
    .xirq_req(xirq_req), .x_mask(x_mask), .irq_any(irq_any),
    .irq_idx(irq_idx), .base(base_eff), .vec_next(vec_next),
    .src(src), .wake(wake)
  );

  always_comb begin
    vec_d = vec_q;
    if (vec_fetch) vec_d = vec_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= VEC_POR;
    else        vec_q <= vec_d;
  end

  assign vec_addr = vec_q;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        vec_fetch,
  input logic        freeze,
  input logic        trap_req,
  input logic        swi_req,
  input logic [2:0]  rst_cause,
  input logic        wake,
  input logic [15:0] vec_addr
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_fetch |=> $stable(vec_addr));

  assert_por_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fetch && rst_cause[2]) |=> (vec_addr == 16'hFFFE));

  assert_trap_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fetch && rst_cause == 3'b000 && trap_req) |=> (vec_addr[7:0] == 8'hF8));

  assert_swi_wake_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_req || trap_req || rst_cause != 3'b000) |-> wake);

  assert_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fetch && !wake) |=> (vec_addr[7:0] == 8'h80));

  assert_freeze_page_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fetch && freeze && rst_cause == 3'b000) |=> (vec_addr[15:8] == 8'hFF));
endmodule

bind irq_vector_sel irqv_checker u_chk (
  .clk(clk), .rst_n(rst_n), .vec_fetch(vec_fetch), .freeze(freeze),
  .trap_req(trap_req), .swi_req(swi_req), .rst_cause(rst_cause),
  .wake(wake), .vec_addr(vec_addr)
);

// File: tb/sim_irq_vector_sel.sv
module sim_irq_vector_sel;
  localparam int NI = 57;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NI-1:0] irq_req;
  logic          xirq_req, swi_req, trap_req;
  logic [2:0]    rst_cause;
  logic          i_mask, x_mask, vec_fetch, base_wr, freeze;
  logic [7:0]    base_wdata;
  logic [15:0]   vec_addr;
  logic          wake;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  irq_vector_sel #(.NUM_IRQ(NI)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .xirq_req(xirq_req),
    .swi_req(swi_req), .trap_req(trap_req), .rst_cause(rst_cause),
    .i_mask(i_mask), .x_mask(x_mask), .vec_fetch(vec_fetch),
    .base_wr(base_wr), .base_wdata(base_wdata), .freeze(freeze),
    .vec_addr(vec_addr), .wake(wake)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clear_reqs();
    irq_req = '0; xirq_req = 0; swi_req = 0; trap_req = 0; rst_cause = 3'b000;
    i_mask = 0; x_mask = 0; freeze = 0;
  endtask

  // Pulse the strobe for one edge, sample the latched vector afterwards.
  task automatic fetch(input string tag, input logic [15:0] exp);
    @(negedge clk); vec_fetch = 1;
    @(negedge clk); vec_fetch = 0;
    chk(tag, vec_addr, exp);
  endtask

  task automatic t_reset();
    chk("R1 reset vector", vec_addr, 16'hFFFE);
    chk("R1 wake idle", {15'd0, wake}, 16'd0);
    fetch("R1/R9 reset base spurious", 16'hFF80);
  endtask

  task automatic t_base();
    @(negedge clk); base_wr = 1; base_wdata = 8'h3C;
    @(negedge clk); base_wr = 0;
    fetch("R10 programmed base", 16'h3C80);
  endtask

  task automatic t_irq();
    irq_req = '0; irq_req[0] = 1;  fetch("R7 lowest source", 16'h3C82);
    irq_req = '0; irq_req[56] = 1; fetch("R7 highest source", 16'h3CF2);
    irq_req = '0; irq_req[5] = 1; irq_req[40] = 1;
    fetch("R7 priority 40 over 5", 16'h3CD2);
    irq_req = '0;
  endtask

  task automatic t_imask();
    i_mask = 1; irq_req[10] = 1;
    fetch("R8 masked I source", 16'h3C80);
    chk("R8 no wake when masked", {15'd0, wake}, 16'd0);
    clear_reqs();
  endtask

  task automatic t_xirq();
    xirq_req = 1; irq_req[56] = 1;
    fetch("R6 X over I", 16'h3CF4);
    x_mask = 1;
    fetch("R6 X masked", 16'h3CF2);
    clear_reqs();
  endtask

  task automatic t_swi();
    swi_req = 1; xirq_req = 1;
    fetch("R5 SWI over X", 16'h3CF6);
    i_mask = 1; x_mask = 1;
    fetch("R5 SWI ignores masks", 16'h3CF6);
    clear_reqs();
  endtask

  task automatic t_trap();
    trap_req = 1; swi_req = 1; i_mask = 1; x_mask = 1;
    fetch("R4 trap over SWI", 16'h3CF8);
    clear_reqs();
  endtask

  task automatic t_rst();
    trap_req = 1; freeze = 1;
    rst_cause = 3'b001; fetch("R3 cause0", 16'hFFFA);
    rst_cause = 3'b011; fetch("R3 cause1 over 0", 16'hFFFC);
    rst_cause = 3'b111; fetch("R3 cause2 over all", 16'hFFFE);
    clear_reqs();
  endtask

  task automatic t_freeze();
    irq_req[0] = 1; freeze = 1;
    fetch("R11 frozen page", 16'hFF82);
    freeze = 0;
    fetch("R11 page restored", 16'h3C82);
    clear_reqs();
  endtask

  task automatic t_hold();
    irq_req[3] = 1;
    fetch("R2 fetched", 16'h3C88);
    trap_req = 1;
    repeat (3) @(negedge clk);
    chk("R2 held without fetch", vec_addr, 16'h3C88);
    clear_reqs();
  endtask

  task automatic t_wake();
    @(negedge clk); i_mask = 1; irq_req[7] = 1;
    #1 chk("R12 masked I no wake", {15'd0, wake}, 16'd0);
    i_mask = 0;
    #1 chk("R12 I wake before edge", {15'd0, wake}, 16'd1);
    clear_reqs(); x_mask = 1; xirq_req = 1;
    #1 chk("R12 masked X no wake", {15'd0, wake}, 16'd0);
    x_mask = 0;
    #1 chk("R12 X wake", {15'd0, wake}, 16'd1);
    clear_reqs(); trap_req = 1;
    #1 chk("R12 trap wake", {15'd0, wake}, 16'd1);
    clear_reqs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_reqs();
    vec_fetch = 0; base_wr = 0; base_wdata = 8'h00;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_base();
    t_irq();
    t_imask();
    t_xirq();
    t_swi();
    t_trap();
    t_rst();
    t_freeze();
    t_hold();
    t_wake();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule